// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block takes eight pin signals that arrive straight from the pad logic and produces eight independent interrupt request lines. Output channel k belongs to input k alone. Each channel works in one of two modes.

- **Edge mode.** Rising and falling transitions are each enabled separately. A detected, enabled transition is held in a sticky status bit until software clears it.
- **Level mode.** The same two enable bits take new meanings. The first turns the channel on. The second picks the active polarity. The status bit then tracks the synchronized pin against that polarity.

Software reaches the block through a bank of 32-bit registers:

- a mode register;
- the two enable registers, each with its own write-1-to-set and write-1-to-clear alias;
- two transition-capture registers, which record every edge whether or not it is enabled;
- the status register, whose bits drive the interrupt outputs.

Masking a channel is a single alias write that clears its enable bit, and no read-modify-write is needed. Pins pass through a two-flop synchronizer before detection.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and all interrupt outputs are low.
- R2: The mode register at offset 0x00 reads back as written. A bit value of 1 puts that channel in level mode, and 0 puts it in edge mode.
- R3: Each enable register supports three kinds of write:
  - A direct write replaces the whole register. The first enable register (rise) is at 0x04 and the second (fall) is at 0x10.
  - A write to a set alias (0x08 for rise, 0x14 for fall) sets every bit written as 1.
  - A write to a clear alias (0x0C for rise, 0x18 for fall) clears every bit written as 1.
  - Bits written as 0 in either alias stay unchanged.
- R4: A pin level first sampled at clock edge n reaches the status register at edge n+2. A level held for one cycle before the pin changes is therefore seen as a transition.
- R5: In edge mode, an enabled rising edge or an enabled falling edge sets that channel's status bit. A disabled edge leaves the status bit unchanged.
- R6: Every synchronized rising edge sets the bit at offset 0x1C, and every falling edge sets the bit at 0x20. This holds in either mode and regardless of the enables. Writing 1 to a bit clears it.
- R7: In edge mode, writing 1 to a status bit at offset 0x24 clears it. If an enabled edge arrives in the same cycle as that write, the bit stays set.
- R8: In level mode, each status bit is updated every cycle. It becomes 1 exactly when the channel's rise enable is 1 and the synchronized pin equals its fall enable bit, where 1 means active-high. Writes to the status register have no effect on level channels.
- R9: Interrupt output k always equals status bit k, and the status register reads back on bits 7:0 at 0x24.
- R10: Register values occupy bits 7:0. Upper read bits are 0. The alias offsets and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw pin levels, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 8 | Interrupt request per channel |

## Verification
The bench aims at four corner cases, each with a clear symptom if the design gets it wrong.

- **Clear versus edge in the same cycle.** A status clear is timed to land in the cycle an enabled edge is detected. A design that gave the clear priority would drop that interrupt.
- **Exact synchronizer latency.** The bench measures the delay from pin to status. A design with one flop too many or too few would move the interrupt by a cycle.
- **Reuse of the enable pair in level mode.** The polarity bit is flipped while the pin is held still. A design that ignored the mode would keep the line quiet, or would latch the interrupt instead of following the pin.
- **Disabled edges.** The bench checks that disabled edges still appear in the capture registers while leaving status untouched. A design that gated capture with the enables would leave those registers empty.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    // Byte offsets of the register bank (software-visible layout).
    localparam int unsigned OFF_MODE     = 'h00;
    localparam int unsigned OFF_RISE_EN  = 'h04;
    localparam int unsigned OFF_RISE_SET = 'h08;
    localparam int unsigned OFF_RISE_CLR = 'h0C;
    localparam int unsigned OFF_FALL_EN  = 'h10;
    localparam int unsigned OFF_FALL_SET = 'h14;
    localparam int unsigned OFF_FALL_CLR = 'h18;
    localparam int unsigned OFF_RISE_HIT = 'h1C;
    localparam int unsigned OFF_FALL_HIT = 'h20;
    localparam int unsigned OFF_STATUS   = 'h24;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int NUM_CH = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] lvl_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    // Index 0..STAGES-1 are synchronizer flops; index STAGES holds the previous sample.
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][NUM_CH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int s = 1; s < DEPTH; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs #(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] lvl,
    input  logic [NUM_CH-1:0] rise_det,
    input  logic [NUM_CH-1:0] fall_det,
    output logic [NUM_CH-1:0] mode_o,
    output logic [NUM_CH-1:0] ien_r_o,
    output logic [NUM_CH-1:0] ien_f_o,
    output logic [NUM_CH-1:0] rise_hit_o,
    output logic [NUM_CH-1:0] fall_hit_o,
    output logic [NUM_CH-1:0] status_o
);
    import pin_irq_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0] mode;
        logic [NUM_CH-1:0] ien_r;
        logic [NUM_CH-1:0] ien_f;
        logic [NUM_CH-1:0] rise_hit;
        logic [NUM_CH-1:0] fall_hit;
        logic [NUM_CH-1:0] status;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic sel(input logic we, input logic [ADDR_W-1:0] a, input int unsigned off);
        return we && (a == ADDR_W'(off));
    endfunction

    logic [NUM_CH-1:0] st_clr, rh_clr, fh_clr, edge_set, edge_next, lvl_next;

    always_comb begin
        bank_d = bank_q;

        if (sel(wr_en, addr, OFF_MODE))     bank_d.mode  = wbits;
        if (sel(wr_en, addr, OFF_RISE_EN))  bank_d.ien_r = wbits;
        if (sel(wr_en, addr, OFF_RISE_SET)) bank_d.ien_r = bank_q.ien_r | wbits;
        if (sel(wr_en, addr, OFF_RISE_CLR)) bank_d.ien_r = bank_q.ien_r & ~wbits;
        if (sel(wr_en, addr, OFF_FALL_EN))  bank_d.ien_f = wbits;
        if (sel(wr_en, addr, OFF_FALL_SET)) bank_d.ien_f = bank_q.ien_f | wbits;
        if (sel(wr_en, addr, OFF_FALL_CLR)) bank_d.ien_f = bank_q.ien_f & ~wbits;

        rh_clr = sel(wr_en, addr, OFF_RISE_HIT) ? wbits : '0;
        fh_clr = sel(wr_en, addr, OFF_FALL_HIT) ? wbits : '0;
        st_clr = sel(wr_en, addr, OFF_STATUS)   ? wbits : '0;

        // Capture every transition; a new edge outranks a clear in the same cycle.
        bank_d.rise_hit = (bank_q.rise_hit & ~rh_clr) | rise_det;
        bank_d.fall_hit = (bank_q.fall_hit & ~fh_clr) | fall_det;

        // Edge channels: sticky, set wins over clear.
        edge_set  = (bank_q.ien_r & rise_det) | (bank_q.ien_f & fall_det);
        edge_next = (bank_q.status & ~st_clr) | edge_set;
        // Level channels: enable pair reused as on/off plus polarity.
        lvl_next  = bank_q.ien_r & ~(lvl ^ bank_q.ien_f);

        bank_d.status = (bank_q.mode & lvl_next) | (~bank_q.mode & edge_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mode_o     = bank_q.mode;
    assign ien_r_o    = bank_q.ien_r;
    assign ien_f_o    = bank_q.ien_f;
    assign rise_hit_o = bank_q.rise_hit;
    assign fall_hit_o = bank_q.fall_hit;
    assign status_o   = bank_q.status;
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);
    import pin_irq_pkg::*;

    logic [NUM_CH-1:0] lvl_w, rise_w, fall_w;
    logic [NUM_CH-1:0] mode_w, ien_r_w, ien_f_w, rise_hit_w, fall_hit_w, status_w;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_CH];

    pin_irq_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    pin_irq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wbits      (wdata[NUM_CH-1:0]),
        .lvl        (lvl_w),
        .rise_det   (rise_w),
        .fall_det   (fall_w),
        .mode_o     (mode_w),
        .ien_r_o    (ien_r_w),
        .ien_f_o    (ien_f_w),
        .rise_hit_o (rise_hit_w),
        .fall_hit_o (fall_hit_w),
        .status_o   (status_w)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_MODE):     rdata[NUM_CH-1:0] = mode_w;
            ADDR_W'(OFF_RISE_EN):  rdata[NUM_CH-1:0] = ien_r_w;
            ADDR_W'(OFF_FALL_EN):  rdata[NUM_CH-1:0] = ien_f_w;
            ADDR_W'(OFF_RISE_HIT): rdata[NUM_CH-1:0] = rise_hit_w;
            ADDR_W'(OFF_FALL_HIT): rdata[NUM_CH-1:0] = fall_hit_w;
            ADDR_W'(OFF_STATUS):   rdata[NUM_CH-1:0] = status_w;
            default:               rdata = '0;
        endcase
    end

    assign irq = status_w;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] mode,
    input logic [NUM_CH-1:0] ien_r,
    input logic [NUM_CH-1:0] rise_hit
);
    import pin_irq_pkg::*;

    logic [NUM_CH-1:0] st_clr, rh_clr;
    assign st_clr = (wr_en && addr == ADDR_W'(OFF_STATUS))   ? wdata[NUM_CH-1:0] : '0;
    assign rh_clr = (wr_en && addr == ADDR_W'(OFF_RISE_HIT)) ? wdata[NUM_CH-1:0] : '0;

    AST_STATUS_READ_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_STATUS)) |-> (rdata[NUM_CH-1:0] == irq)); // R9

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NUM_CH] == '0); // R10

    AST_EDGE_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq) & ~$past(mode) & ~$past(st_clr) & ~irq) == '0)); // R7

    AST_LEVEL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(mode) & ~$past(ien_r) & irq) == '0)); // R8

    AST_RISE_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise_hit) & ~$past(rh_clr) & ~rise_hit) == '0)); // R6

    AST_SET_ALIAS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_RISE_SET))
        |=> ((ien_r & $past(wdata[NUM_CH-1:0])) == $past(wdata[NUM_CH-1:0]))); // R3

    AST_CLR_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_RISE_CLR))
        |=> ((ien_r & $past(wdata[NUM_CH-1:0])) == '0)); // R3
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .mode     (mode_w),
    .ien_r    (ien_r_w),
    .rise_hit (rise_hit_w)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
    localparam int A_MODE = 'h00, A_REN = 'h04, A_RSET = 'h08, A_RCLR = 'h0C;
    localparam int A_FEN = 'h10, A_FSET = 'h14, A_FCLR = 'h18;
    localparam int A_RHIT = 'h1C, A_FHIT = 'h20, A_STAT = 'h24;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  pins = '0;
    logic        wr_en = 0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int total = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pin_irq_ctrl i_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0] m_mode, m_ren, m_fen, m_rhit, m_fhit, m_stat;
    logic [7:0] hist[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        case (a)
            A_MODE: return {24'h0, m_mode};
            A_REN:  return {24'h0, m_ren};
            A_FEN:  return {24'h0, m_fen};
            A_RHIT: return {24'h0, m_rhit};
            A_FHIT: return {24'h0, m_fhit};
            A_STAT: return {24'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ren = 0; m_fen = 0; m_rhit = 0; m_fhit = 0; m_stat = 0;
            hist = '{8'h0, 8'h0, 8'h0};
        end else begin
            logic [7:0] cur, prv, n_ren, n_fen, n_mode, n_rhit, n_fhit, n_stat, wb;
            cur = hist[1];
            prv = hist[0];
            wb = wdata[7:0];
            n_mode = m_mode; n_ren = m_ren; n_fen = m_fen;
            n_rhit = m_rhit; n_fhit = m_fhit; n_stat = m_stat;
            if (wr_en) begin
                case (int'(addr))
                    A_MODE: n_mode = wb;
                    A_REN:  n_ren = wb;
                    A_RSET: n_ren = m_ren | wb;
                    A_RCLR: n_ren = m_ren & ~wb;
                    A_FEN:  n_fen = wb;
                    A_FSET: n_fen = m_fen | wb;
                    A_FCLR: n_fen = m_fen & ~wb;
                    A_RHIT: n_rhit = m_rhit & ~wb;
                    A_FHIT: n_fhit = m_fhit & ~wb;
                    A_STAT: n_stat = m_stat & ~wb;
                    default: ;
                endcase
            end
            for (int ch = 0; ch < 8; ch++) begin
                bit r, f;
                r = cur[ch] && !prv[ch];
                f = !cur[ch] && prv[ch];
                if (r) n_rhit[ch] = 1;
                if (f) n_fhit[ch] = 1;
                if (m_mode[ch])
                    n_stat[ch] = m_ren[ch] && (cur[ch] == m_fen[ch]);
                else if ((m_ren[ch] && r) || (m_fen[ch] && f))
                    n_stat[ch] = 1;
            end
            m_mode = n_mode; m_ren = n_ren; m_fen = n_fen;
            m_rhit = n_rhit; m_fhit = n_fhit; m_stat = n_stat;
            hist.push_back(pins);
            void'(hist.pop_front());
        end
        #2;
        if (rst_n) chk("R9 irq vs model", {24'h0, irq}, {24'h0, m_stat});
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = 6'(a); wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string tag, input int a);
        @(negedge clk);
        addr = 6'(a);
        #1;
        chk(tag, rdata, model_read(a));
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        // R1 / R10: reset state and alias reads
        chk("R1 irq after reset", {24'h0, irq}, 32'h0);
        for (int a = 0; a <= 'h28; a += 4) rd_chk("R1 R10 reset read", a);

        // R2 mode register
        wr(A_MODE, 32'hFFFF_FFA5);
        rd_chk("R2 mode readback", A_MODE);
        chk("R2 mode value", rdata, 32'hA5);
        wr(A_MODE, 0);

        // R3 enable aliases
        wr(A_REN, 32'h0F);  wr(A_RSET, 32'hF0); rd_chk("R3 rise set alias", A_REN);
        chk("R3 rise value FF", rdata, 32'hFF);
        wr(A_RCLR, 32'h3C); rd_chk("R3 rise clr alias", A_REN);
        chk("R3 rise value C3", rdata, 32'hC3);
        rd_chk("R10 alias read zero", A_RSET);
        wr(A_FEN, 32'h55);  wr(A_FSET, 32'h0A); wr(A_FCLR, 32'h01);
        rd_chk("R3 fall aliases", A_FEN);
        chk("R3 fall value 5E", rdata, 32'h5E);

        // R4/R5 edge mode timing
        wr(A_REN, 32'h01); wr(A_FEN, 32'h02);
        @(negedge clk) pins = 8'h01;
        @(posedge clk); @(posedge clk); #2;
        chk("R4 no irq before edge n+2", {31'h0, irq[0]}, 32'h0);
        @(posedge clk); #2;
        chk("R4 R5 rising irq at n+2", {31'h0, irq[0]}, 32'h1);
        @(negedge clk) pins = 8'h03;
        wait_cyc(4);
        chk("R5 disabled rise ignored", {24'h0, irq}, 32'h01);
        rd_chk("R6 rise capture", A_RHIT);
        @(negedge clk) pins = 8'h01;
        wait_cyc(4);
        chk("R5 enabled fall", {24'h0, irq}, 32'h03);
        @(negedge clk) pins = 8'h05;
        wait_cyc(4);
        @(negedge clk) pins = 8'h01;
        wait_cyc(4);
        chk("R5 ch2 edges disabled", {31'h0, irq[2]}, 32'h0);
        rd_chk("R6 fall capture", A_FHIT);
        chk("R6 fall capture value", rdata, 32'h06);

        // R7 clear
        wr(A_STAT, 32'h01);
        chk("R7 w1c status", {24'h0, irq}, 32'h02);
        wr(A_RHIT, 32'hFF);
        rd_chk("R6 capture cleared", A_RHIT);
        chk("R6 capture zero", rdata, 32'h0);
        @(negedge clk) pins = 8'h00;
        wait_cyc(4);
        wr(A_STAT, 32'h03);
        chk("R7 cleared both", {24'h0, irq}, 32'h0);
        // clear lands in the same cycle as the rise detection
        @(negedge clk) pins = 8'h01;
        @(posedge clk); @(posedge clk);
        wr(A_STAT, 32'h01);
        chk("R7 edge wins over clear", {31'h0, irq[0]}, 32'h1);
        wr(A_STAT, 32'hFF);
        chk("R7 cleared again", {24'h0, irq}, 32'h0);

        // R8 level mode
        wr(A_MODE, 32'h10); wr(A_REN, 32'h10); wr(A_FEN, 32'h10);
        @(negedge clk) pins = 8'h11;
        wait_cyc(4);
        chk("R8 active high", {24'h0, irq}, 32'h10);
        wr(A_STAT, 32'h10);
        chk("R8 status write ignored", {24'h0, irq}, 32'h10);
        @(negedge clk) pins = 8'h01;
        wait_cyc(4);
        chk("R8 level drop", {24'h0, irq}, 32'h0);
        wr(A_FCLR, 32'h10);
        wait_cyc(1);
        chk("R8 active low", {24'h0, irq}, 32'h10);
        wr(A_RCLR, 32'h10);
        wait_cyc(1);
        chk("R8 channel off", {24'h0, irq}, 32'h0);

        // Mixed pattern, model compared every cycle
        wr(A_MODE, 32'h0F); wr(A_REN, 32'hA6); wr(A_FEN, 32'h5B);
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pins = lfsr[7:0];
            if (i % 37 == 5) begin
                wr_en = 1; addr = 6'(A_STAT); wdata = {24'h0, lfsr[15:8]};
                @(negedge clk) wr_en = 0;
            end
            if (i == 200) begin
                wr_en = 1; addr = 6'(A_MODE); wdata = 32'hF0;
                @(negedge clk) wr_en = 0;
            end
        end
        for (int a = 0; a <= 'h24; a += 4) rd_chk("R3 R6 R10 final readback", a);

        done = 1;
        summary();
        $finish;
    end
endmodule